// File: doc/BRIEF.md
# Serial EEPROM Command Sequencer

This block is the slave-side protocol engine of a small serial EEPROM. It runs on a system clock and oversamples the serial pins. Serial input bits are taken on rising serial-clock edges, and the output bit changes on falling edges, so both SPI mode 0 and mode 3 hosts work. The first byte after chip select falls is an 8-bit opcode. For memory accesses an address byte follows. For the 512-byte array, the ninth address bit travels in bit 3 of the read and write opcodes.

Read data streams from a behavioural byte array. The read address increments without limit and wraps at the top of the array. Write data collects in a 16-byte page buffer, and its address wraps inside the current page. When chip select rises after a complete write sequence, the buffered bytes are committed and a self-timed busy period starts, modelled by a clock counter. During that period only the status read opcode is honoured.

Write-protection policy is not part of this block. It lives in a separate unit, which reads the two stored protection bits from a port.

Top module: `spi_eeprom_seq`

## Requirements
- R1: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Opcode 0x05 returns the status byte {4'b1111, prot[1], prot[0], write_enable, busy} MSB first, reloading it every 8 bits.
- R2: `so_oe` is low in reset and whenever chip select has been high for two synchronised cycles. It is high while selected.
- R3: The serial input is sampled on rising serial-clock edges and `so` changes only after falling edges, MSB first. Transfers give identical results in mode 0 (clock idles low) and mode 3 (clock idles high).
- R4: Read opcode 0000_A011 followed by an address byte forms the address {A, byte}. Data then streams with the address incrementing by one per byte and wrapping from the last location to 0.
- R5: Write opcode 0000_A010 is ignored unless the write-enable latch is set.
- R6: Write data bytes go to a 16-byte page buffer. The address increments inside the page, wrapping from offset 15 to offset 0 of the same page.
- R7: A write commits only when chip select rises after the opcode, the address and at least one whole data byte. A trailing partial byte, or the absence of data, aborts it: no commit, no busy, and the write-enable latch unchanged.
- R8: A commit raises `busy` for exactly WRITE_CYCLES clocks and clears the write-enable latch. The status busy bit follows `busy`.
- R9: While busy, every opcode other than 0x05 is ignored.
- R10: An unrecognised opcode makes the rest of that chip-select period ignored.
- R11: Opcode 0x01 followed by a whole byte, with the write-enable latch set, stores data bits [3:2] into `prot_bits` when chip select rises and clears the latch. Without the latch it has no effect.
- R12: After reset every array location reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Output enable for the `so` pad driver |
| prot_bits | output | 2 | Stored protection field for the protection unit |
| busy | output | 1 | Self-timed write in progress |

## Verification
Reads are tried in mode 0 and mode 3 over the same locations. A stream starting two bytes below the top of the array crosses both the array wrap and a page boundary, which separates continuous increment from page-limited increment. A three-byte write starting at page offset 14 shows the wrap inside the page. Aborted writes (a trailing nibble, or an address with no data), a write without enable, opcodes sent during busy and an unknown opcode followed by a valid one show which inputs leave the array and the status untouched. The busy width is measured in clocks against the parameter.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_WDAT,
        ST_RDAT,
        ST_SRRD,
        ST_SRWR,
        ST_SKIP
    } seq_st_e;

    localparam logic [7:0] OPC_SET_WE = 8'h06;
    localparam logic [7:0] OPC_CLR_WE = 8'h04;
    localparam logic [7:0] OPC_STAT_R = 8'h05;
    localparam logic [7:0] OPC_STAT_W = 8'h01;

    // memory opcodes: upper nibble zero, bit 3 optional address bit
    function automatic logic opc_is_mem(input logic [7:0] op, input logic [2:0] low,
                                        input logic a8_used);
        return (op[7:4] == 4'h0) && (op[2:0] == low) && (a8_used || !op[3]);
    endfunction

endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_q, pipe_d;

    always_comb begin
        pipe_d = pipe_q;
        pipe_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/eep_wtimer.sv
module eep_wtimer #(
    parameter int WRITE_CYCLES = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(WRITE_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(WRITE_CYCLES);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (start)            cnt_d = LOAD;
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/eep_mem.sv
module eep_mem #(
    parameter int ADDR_W     = 9,
    parameter int PAGE_BYTES = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [ADDR_W-1:0]                rd_addr,
    output logic [7:0]                       rd_data,
    input  logic                             commit,
    input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page,
    input  logic [PAGE_BYTES-1:0][7:0]       pbuf,
    input  logic [PAGE_BYTES-1:0]            mask
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PW    = $clog2(PAGE_BYTES);

    logic [7:0] cell_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) cell_q[k] <= 8'hFF;
        end else if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (mask[i]) cell_q[{page, PW'(i)}] <= pbuf[i];
            end
        end
    end

    assign rd_data = cell_q[rd_addr];
endmodule

// File: rtl/spi_eeprom_seq.sv
module spi_eeprom_seq
    import eep_pkg::*;
#(
    parameter int ADDR_W       = 9,
    parameter int PAGE_BYTES   = 16,
    parameter int WRITE_CYCLES = 250000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       si,
    output logic       so,
    output logic       so_oe,
    output logic [1:0] prot_bits,
    output logic       busy
);
    localparam int   PW      = $clog2(PAGE_BYTES);
    localparam int   PAGE_W  = ADDR_W - PW;
    localparam logic HAS_A8  = (ADDR_W > 8);

    typedef struct packed {
        seq_st_e                     st;
        logic                        cs_p;
        logic                        sck_p;
        logic [2:0]                  bcnt;
        logic [7:0]                  sh;
        logic                        is_rd;
        logic                        op_a8;
        logic [ADDR_W-1:0]           addr;
        logic                        got_byte;
        logic [2:0]                  ocnt;
        logic [7:0]                  oreg;
        logic                        so;
        logic                        wel;
        logic [1:0]                  bp;
        logic [PAGE_BYTES-1:0]       mask;
        logic [PAGE_BYTES-1:0][7:0]  pbuf;
    } seq_regs_t;

    seq_regs_t q, n;

    // pin synchroniser: {si, sck, cs_n}
    logic [2:0] pins_s;
    eep_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({si, sck, cs_n}), .dout(pins_s)
    );

    logic cs_s, sck_s, si_s;
    assign cs_s  = pins_s[0];
    assign sck_s = pins_s[1];
    assign si_s  = pins_s[2];

    logic cs_rise, cs_fall, sck_rise, sck_fall;
    assign cs_rise  =  cs_s  & ~q.cs_p;
    assign cs_fall  = ~cs_s  &  q.cs_p;
    assign sck_rise =  sck_s & ~q.sck_p & ~cs_s;
    assign sck_fall = ~sck_s &  q.sck_p & ~cs_s;

    logic              commit;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        rd_data;
    logic [7:0]        sh_new;
    logic [8:0]        a_full;
    logic [7:0]        status;

    assign sh_new = {q.sh[6:0], si_s};
    assign a_full = {q.op_a8, sh_new};
    assign status = {4'hF, q.bp, q.wel, busy};
    assign rd_addr = (q.st == ST_ADDR) ? a_full[ADDR_W-1:0] : q.addr;

    always_comb begin
        n        = q;
        n.cs_p   = cs_s;
        n.sck_p  = sck_s;
        commit   = 1'b0;

        if (cs_rise) begin
            if (q.st == ST_WDAT && q.bcnt == 3'd0 && q.got_byte) begin
                commit = 1'b1;
                n.wel  = 1'b0;
            end
            if (q.st == ST_SRWR && q.bcnt == 3'd0 && q.got_byte && q.wel) begin
                n.bp  = q.sh[3:2];
                n.wel = 1'b0;
            end
            n.st = ST_IDLE;
        end else if (cs_fall) begin
            n.st       = ST_OPC;
            n.bcnt     = 3'd0;
            n.got_byte = 1'b0;
            n.mask     = '0;
        end else if (q.st != ST_IDLE) begin
            if (sck_rise) begin
                n.sh   = sh_new;
                n.bcnt = q.bcnt + 1'b1;
                if (q.bcnt == 3'd7) begin
                    unique case (q.st)
                        ST_OPC: begin
                            n.st = ST_SKIP;
                            if (sh_new == OPC_STAT_R) begin
                                n.st   = ST_SRRD;
                                n.oreg = status;
                                n.ocnt = 3'd0;
                            end else if (!busy) begin
                                if (sh_new == OPC_SET_WE) begin
                                    n.wel = 1'b1;
                                end else if (sh_new == OPC_CLR_WE) begin
                                    n.wel = 1'b0;
                                end else if (sh_new == OPC_STAT_W) begin
                                    n.st = ST_SRWR;
                                end else if (opc_is_mem(sh_new, 3'b011, HAS_A8)) begin
                                    n.st    = ST_ADDR;
                                    n.is_rd = 1'b1;
                                    n.op_a8 = sh_new[3];
                                end else if (opc_is_mem(sh_new, 3'b010, HAS_A8) && q.wel) begin
                                    n.st    = ST_ADDR;
                                    n.is_rd = 1'b0;
                                    n.op_a8 = sh_new[3];
                                end
                            end
                        end
                        ST_ADDR: begin
                            if (q.is_rd) begin
                                n.st   = ST_RDAT;
                                n.oreg = rd_data;
                                n.ocnt = 3'd0;
                                n.addr = a_full[ADDR_W-1:0] + 1'b1;
                            end else begin
                                n.st   = ST_WDAT;
                                n.addr = a_full[ADDR_W-1:0];
                            end
                        end
                        ST_WDAT: begin
                            n.pbuf[q.addr[PW-1:0]] = sh_new;
                            n.mask[q.addr[PW-1:0]] = 1'b1;
                            n.addr[PW-1:0]         = q.addr[PW-1:0] + 1'b1;
                            n.got_byte             = 1'b1;
                        end
                        ST_SRWR: n.got_byte = 1'b1;
                        default: ;
                    endcase
                end
            end
            if (sck_fall && (q.st == ST_RDAT || q.st == ST_SRRD)) begin
                n.so   = q.oreg[7];
                n.oreg = {q.oreg[6:0], 1'b0};
                n.ocnt = q.ocnt + 1'b1;
                if (q.ocnt == 3'd7) begin
                    if (q.st == ST_RDAT) begin
                        n.oreg = rd_data;
                        n.addr = q.addr + 1'b1;
                    end else begin
                        n.oreg = status;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.cs_p  <= 1'b1;
        end else begin
            q <= n;
        end
    end

    eep_mem #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_mem (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
        .commit(commit), .page(q.addr[ADDR_W-1:PW]), .pbuf(q.pbuf), .mask(q.mask)
    );

    eep_wtimer #(.WRITE_CYCLES(WRITE_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(commit), .busy(busy)
    );

    logic                  wel_now;
    logic [PAGE_BYTES-1:0] mask_now;
    logic [PAGE_W-1:0]     page_now;
    assign wel_now  = q.wel;
    assign mask_now = q.mask;
    assign page_now = q.addr[ADDR_W-1:PW];

    assign so        = q.so;
    assign so_oe     = (q.st != ST_IDLE);
    assign prot_bits = q.bp;
endmodule

// File: rtl/eep_seq_chk.sv
module eep_seq_chk #(
    parameter int PAGE_BYTES = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cs_s,
    input logic                  sck_fall,
    input logic                  so,
    input logic                  so_oe,
    input logic                  commit,
    input logic                  busy,
    input logic                  wel,
    input logic [PAGE_BYTES-1:0] mask
);
    a_r2_so_off_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && $past(cs_s)) |-> !so_oe);

    a_r3_so_moves_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(so) |-> $past(sck_fall));

    a_r7_commit_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> ($countones(mask) > 0));

    a_r8_wel_cleared_by_commit: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !wel);

    a_r8_busy_from_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(commit));

    a_r9_no_commit_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !busy);
endmodule

bind spi_eeprom_seq eep_seq_chk #(.PAGE_BYTES(PAGE_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sck_fall(sck_fall), .so(so),
    .so_oe(so_oe), .commit(commit), .busy(busy), .wel(wel_now), .mask(mask_now)
);

// File: tb/tb_spi_eeprom_seq.sv
module tb_spi_eeprom_seq;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 9;
    localparam int WCYC       = 1000;
    localparam int HALF       = 8;
    localparam int DEPTH      = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic si = 1'b0;
    logic so, so_oe, busy;
    logic [1:0] prot_bits;

    int n_checks = 0;
    int n_errors = 0;
    bit mode3 = 1'b0;
    bit done = 1'b0;

    logic [7:0] mem_ref [DEPTH];
    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_eeprom_seq #(.ADDR_W(ADDR_W), .PAGE_BYTES(16), .WRITE_CYCLES(WCYC)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .so(so), .so_oe(so_oe), .prot_bits(prot_bits), .busy(busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        while (exp_q.size() > 0 && got_q.size() > 0) begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic logic [7:0] g = got_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(g === e, t, int'(g), int'(e));
        end
    end

    task automatic half_wait();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic bits(input int nb, input logic [7:0] tx, output logic [7:0] rx);
        rx = 8'h00;
        for (int b = 0; b < nb; b++) begin
            if (mode3) sck = 1'b0;
            si = tx[7-b];
            half_wait();
            rx = {rx[6:0], so};
            sck = 1'b1;
            half_wait();
            if (!mode3) sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        bits(8, tx, rx);
    endtask

    task automatic sel();
        sck = mode3;
        half_wait();
        cs_n = 1'b0;
        half_wait();
    endtask

    task automatic desel();
        half_wait();
        cs_n = 1'b1;
        repeat (4) half_wait();
    endtask

    task automatic cmd(input logic [7:0] op);
        logic [7:0] r;
        sel(); xfer(op, r); desel();
    endtask

    task automatic rdsr(input logic [7:0] exp, input string tag);
        logic [7:0] r;
        exp_q.push_back(exp); tag_q.push_back(tag);
        sel(); xfer(8'h05, r); xfer(8'h00, r); desel();
        got_q.push_back(r);
    endtask

    task automatic rd(input int addr, input int nb, input string tag);
        logic [7:0] r;
        logic [8:0] a = 9'(addr);
        for (int i = 0; i < nb; i++) begin
            exp_q.push_back(mem_ref[(addr + i) % DEPTH]);
            tag_q.push_back(tag);
        end
        sel();
        xfer({4'h0, a[8], 3'b011}, r);
        xfer(a[7:0], r);
        for (int i = 0; i < nb; i++) begin
            xfer(8'h00, r);
            got_q.push_back(r);
        end
        desel();
    endtask

    task automatic wr(input int addr, input logic [23:0] data, input int nb,
                      input int extra, input bit commits, input bit wait_end);
        logic [7:0] r;
        logic [8:0] a = 9'(addr);
        sel();
        xfer({4'h0, a[8], 3'b010}, r);
        xfer(a[7:0], r);
        for (int i = 0; i < nb; i++) xfer(data[23-8*i -: 8], r);
        if (extra > 0) bits(extra, 8'hA5, r);
        if (commits) begin
            for (int i = 0; i < nb; i++) begin
                mem_ref[{a[8:4], 4'(a[3:0] + 4'(i))}] = data[23-8*i -: 8];
            end
        end
        if (wait_end) desel();
        else begin half_wait(); cs_n = 1'b1; end
    endtask

    task automatic wait_ready(input string tag);
        logic [7:0] r;
        int tries = 0;
        do begin
            sel(); xfer(8'h05, r); xfer(8'h00, r); desel();
            tries++;
        end while (r[0] && tries < 60);
        check(!r[0], tag, int'(r), int'(r & 8'hFE));
    endtask

    initial begin
        int wd = 0;
        while (!done && wd < 190000) begin
            @(posedge clk);
            wd++;
        end
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int t_rise, t_fall;
        for (int k = 0; k < DEPTH; k++) mem_ref[k] = 8'hFF;
        repeat (5) @(negedge clk);
        check(so_oe === 1'b0, "R2 so_oe in reset", int'(so_oe), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(busy === 1'b0, "R8 busy idle after reset", int'(busy), 0);
        check(prot_bits === 2'b00, "R11 prot_bits after reset", int'(prot_bits), 0);

        // R1 status and latch control
        rdsr(8'hF0, "R1 status after reset");
        cmd(8'h06);
        rdsr(8'hF2, "R1 WREN sets latch");
        cmd(8'h04);
        rdsr(8'hF0, "R1 WRDI clears latch");

        // R12 erased content, R4 A8 via opcode
        rd(9'h1F3, 2, "R12 erased reads FF");

        // R5 write without enable
        wr(9'h010, 24'hAA0000, 1, 0, 1'b0, 1'b1);
        check(busy === 1'b0, "R5 no busy after unenabled write", int'(busy), 0);
        rd(9'h010, 1, "R5 unenabled write ignored");

        // R6 page wrap, R8 busy status, R9 ignored opcode while busy
        cmd(8'h06);
        wr(9'h1FE, 24'h112233, 3, 0, 1'b1, 1'b1);
        check(busy === 1'b1, "R8 busy after commit", int'(busy), 1);
        rdsr(8'hF1, "R8 status busy and latch cleared");
        cmd(8'h06);
        rdsr(8'hF1, "R9 WREN ignored while busy");
        wait_ready("R8 busy ends");
        rdsr(8'hF0, "R9 latch still clear after busy");

        // R4 continuous read across page and array top, R6 wrapped byte at 0x1F0
        rd(9'h1EF, 2, "R6 page wrap landed at page start");
        rd(9'h1FD, 4, "R4 stream wraps at array top");

        // R3 mode 3 gives identical data
        mode3 = 1'b1;
        rd(9'h1FD, 4, "R3 mode 3 read");
        rdsr(8'hF0, "R3 mode 3 status");
        cmd(8'h06);
        wr(9'h045, 24'hC3_5A_00, 2, 0, 1'b1, 1'b0);
        t_rise = -1; t_fall = -1;
        for (int c = 0; c < WCYC + 40; c++) begin
            @(negedge clk);
            if (busy && t_rise < 0) t_rise = c;
            if (!busy && t_rise >= 0 && t_fall < 0) t_fall = c;
        end
        check(t_rise >= 0 && (t_fall - t_rise) == WCYC, "R8 busy width",
              t_fall - t_rise, WCYC);
        mode3 = 1'b0;
        sck = 1'b0;
        repeat (4) half_wait();
        rd(9'h044, 3, "R3 mode 3 write read in mode 0");

        // R7 aborted writes
        cmd(8'h06);
        wr(9'h020, 24'h5A0000, 1, 4, 1'b0, 1'b1);
        check(busy === 1'b0, "R7 partial byte no busy", int'(busy), 0);
        rdsr(8'hF2, "R7 partial byte keeps latch");
        wr(9'h021, 24'h000000, 0, 0, 1'b0, 1'b1);
        check(busy === 1'b0, "R7 no data no busy", int'(busy), 0);
        rd(9'h020, 2, "R7 aborted writes left array");
        cmd(8'h04);

        // R10 unknown opcode then a valid-looking byte
        begin
            logic [7:0] r;
            sel(); xfer(8'hA6, r); xfer(8'h06, r); desel();
        end
        rdsr(8'hF0, "R10 bytes after unknown opcode ignored");

        // R11 status write
        wr(9'h000, 24'h0, 0, 0, 1'b0, 1'b1);
        begin
            logic [7:0] r;
            sel(); xfer(8'h01, r); xfer(8'h0C, r); desel();
        end
        check(prot_bits === 2'b00, "R11 no effect without latch", int'(prot_bits), 0);
        cmd(8'h06);
        begin
            logic [7:0] r;
            sel(); xfer(8'h01, r); xfer(8'h0C, r); desel();
        end
        check(prot_bits === 2'b11, "R11 prot_bits stored", int'(prot_bits), 3);
        rdsr(8'hFC, "R11 status shows field and latch cleared");
        cmd(8'h06);
        begin
            logic [7:0] r;
            sel(); xfer(8'h01, r); desel();
        end
        check(prot_bits === 2'b11, "R11 opcode alone has no effect", int'(prot_bits), 3);

        repeat (20) @(negedge clk);
        check(so_oe === 1'b0, "R2 so_oe off after deselect", int'(so_oe), 0);
        check(exp_q.size() == 0 && got_q.size() == 0, "R3 scoreboard drained",
              got_q.size(), exp_q.size());
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule